// File: doc/BRIEF.md
# Dual-Bank Multiply-Accumulate Datapath

This block is the arithmetic core of a small signal-processing engine. It holds two independent data memories of 256 signed 16-bit words each. Each memory owns a file of four 8-bit address pointers. A micro-op picks one pointer in each memory, and both words are fetched in the same cycle. They are multiplied as signed 16x16 values, scaled down by 8 bits and folded into a 24-bit accumulator, all within a single clock.

After the fetch, each selected pointer can step by +1, step by -1 or stay where it is. The step wraps modulo 256. Because of this, a filter or correlation loop walks its operand arrays with no address arithmetic in software. A separate pointer write port loads any pointer. Two plain write ports fill the memories.

The accumulator has four operations: keep, add, load and clear. Load replaces the accumulator contents with the new product. When an add overflows, the result clips to the nearest rail of the 24-bit range instead of wrapping, and a flag records the clip.

Top module: `mac_dual_bank`

## Requirements
- R1: After reset, acc_out is 0, acc_sat is 0 and all eight pointers hold address 0. Memory contents are not affected by reset.
- R2: A memory write (mem_a_we or mem_b_we high) stores the word at the given address at the clock edge. A later read through a pointer that holds that address returns the stored word.
- R3: With uop_valid high and acc_op=2 (load), the edge stores floor(A*B/256) into the accumulator as a signed value, where A and B are the words at the selected pointers. The result is visible on acc_out after that same edge.
- R4: With acc_op=1 (add), the edge adds the scaled product to the accumulator.
- R5: If an add leaves the signed 24-bit range, acc_out becomes 8388607 or -8388608, matching the sign of the true sum, and acc_sat goes high. acc_sat goes low again on the next load, clear or non-clipping add.
- R6: acc_op=3 (clear) sets the accumulator and acc_sat to 0. acc_op=0 (keep) leaves both unchanged. With uop_valid low, the accumulator does not change and no pointer steps.
- R7: The step code for each bank selects the pointer update after the read. Code 1 adds one, code 2 subtracts one, and codes 0 and 3 leave the pointer unchanged. The read always uses the value the pointer had before the step.
- R8: Stepping wraps modulo 256: +1 from 255 gives 0, and -1 from 0 gives 255.
- R9: A pointer write (ptr_wr_bank 0 = bank A, 1 = bank B) takes effect at the edge and is used by a micro-op in the next cycle. If the same pointer is written and stepped in the same cycle, the written value wins.
- R10: Each bank selects its pointer independently (sel_a, sel_b from 0 to 3). A step changes only the selected pointer of that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| uop_valid | input | 1 | Micro-op present this cycle |
| sel_a | input | 2 | Pointer used for bank A |
| sel_b | input | 2 | Pointer used for bank B |
| step_a | input | 2 | Step code for bank A pointer (0 none, 1 +1, 2 -1, 3 none) |
| step_b | input | 2 | Step code for bank B pointer |
| acc_op | input | 2 | 0 keep, 1 add, 2 load, 3 clear |
| ptr_wr_en | input | 1 | Pointer write strobe |
| ptr_wr_bank | input | 1 | Bank of the pointer write (0 A, 1 B) |
| ptr_wr_idx | input | 2 | Pointer index to write |
| ptr_wr_val | input | 8 | Value written to the pointer |
| mem_a_we | input | 1 | Bank A memory write enable |
| mem_a_addr | input | 8 | Bank A write address |
| mem_a_wdata | input | 16 | Bank A write data |
| mem_b_we | input | 1 | Bank B memory write enable |
| mem_b_addr | input | 8 | Bank B write address |
| mem_b_wdata | input | 16 | Bank B write data |
| acc_out | output | 24 | Accumulator, signed |
| acc_sat | output | 1 | Last accumulator update clipped |

## Verification
Each micro-op's accumulator result and saturation flag appear one clock edge after the op is presented. A pointer step or pointer write shows up only in the product of the next micro-op. The bench applies every input on a falling edge and reads acc_out and acc_sat on the following falling edge. Pointer effects are judged from the value that a second micro-op produces. The memories are filled so that the word at address k is 16k, which makes a loaded product equal to the product of the two pointer values and reveals the pointer state directly.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'b00,
        STEP_INC  = 2'b01,
        STEP_DEC  = 2'b10,
        STEP_RSVD = 2'b11
    } step_e;

    typedef enum logic [1:0] {
        ACC_KEEP  = 2'b00,
        ACC_ADD   = 2'b01,
        ACC_LOAD  = 2'b10,
        ACC_CLEAR = 2'b11
    } acc_op_e;

endpackage

// File: rtl/mac_bank.sv
// One data bank: word storage plus its file of auto-stepping pointers.
module mac_bank #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter int NPTR   = 4,
    localparam int PSEL_W = $clog2(NPTR),
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_en,
    input  logic [PSEL_W-1:0] ptr_sel,
    input  logic [1:0]        step,
    input  logic              pw_en,
    input  logic [PSEL_W-1:0] pw_idx,
    input  logic [ADDR_W-1:0] pw_val,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] rd_data
);
    import mac_pkg::*;

    logic [ADDR_W-1:0] ptr_q [NPTR];
    logic [ADDR_W-1:0] cur_ptr;
    logic [ADDR_W-1:0] nxt_ptr;
    logic [DATA_W-1:0] mem [DEPTH];

    assign cur_ptr = ptr_q[ptr_sel];

    // Post-access update of the selected pointer; wraps modulo DEPTH.
    always_comb begin
        unique case (step_e'(step))
            STEP_INC:  nxt_ptr = cur_ptr + 1'b1;
            STEP_DEC:  nxt_ptr = cur_ptr - 1'b1;
            STEP_HOLD: nxt_ptr = cur_ptr;
            STEP_RSVD: nxt_ptr = cur_ptr;
            default:   nxt_ptr = cur_ptr;
        endcase
    end

    // Pointer register file; a direct write outranks a step.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPTR; i++) ptr_q[i] <= '0;
        end else begin
            for (int i = 0; i < NPTR; i++) begin
                if (pw_en && (pw_idx == PSEL_W'(i)))
                    ptr_q[i] <= pw_val;
                else if (op_en && (ptr_sel == PSEL_W'(i)))
                    ptr_q[i] <= nxt_ptr;
            end
        end
    end

    // Storage: synchronous write, combinational read through the pointer.
    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    assign rd_data = mem[cur_ptr];

endmodule

// File: rtl/mac_mul.sv
// Signed full-width product, arithmetically scaled into accumulator width.
module mac_mul #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 24,
    parameter int SHIFT  = 8,
    localparam int PROD_W = 2 * DATA_W
) (
    input  logic [DATA_W-1:0]       op_a,
    input  logic [DATA_W-1:0]       op_b,
    output logic signed [ACC_W-1:0] prod_o
);
    logic signed [PROD_W-1:0] full;

    assign full   = $signed(op_a) * $signed(op_b);
    assign prod_o = ACC_W'(full >>> SHIFT);

endmodule

// File: rtl/mac_acc.sv
// Accumulator register with clip-on-overflow addition.
module mac_acc #(
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    op_en,
    input  logic [1:0]              op,
    input  logic signed [ACC_W-1:0] prod,
    output logic signed [ACC_W-1:0] acc_q,
    output logic                    sat_q
);
    import mac_pkg::*;

    localparam logic signed [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [ACC_W:0]   sum;
    logic                    ovf;
    logic signed [ACC_W-1:0] acc_d;
    logic                    sat_d;

    assign sum = {prod[ACC_W-1], prod} + {acc_q[ACC_W-1], acc_q};
    assign ovf = sum[ACC_W] ^ sum[ACC_W-1];

    always_comb begin
        acc_d = acc_q;
        sat_d = sat_q;
        if (op_en) begin
            unique case (acc_op_e'(op))
                ACC_KEEP: begin
                    acc_d = acc_q;
                    sat_d = sat_q;
                end
                ACC_ADD: begin
                    sat_d = ovf;
                    if (ovf) acc_d = sum[ACC_W] ? MINV : MAXV;
                    else     acc_d = sum[ACC_W-1:0];
                end
                ACC_LOAD: begin
                    acc_d = prod;
                    sat_d = 1'b0;
                end
                ACC_CLEAR: begin
                    acc_d = '0;
                    sat_d = 1'b0;
                end
                default: begin
                    acc_d = acc_q;
                    sat_d = sat_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            sat_q <= 1'b0;
        end else begin
            acc_q <= acc_d;
            sat_q <= sat_d;
        end
    end

endmodule

// File: rtl/mac_dual_bank.sv
module mac_dual_bank #(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 8,
    parameter int NPTR       = 4,
    parameter int ACC_W      = 24,
    parameter int PROD_SHIFT = 8,
    localparam int PSEL_W = $clog2(NPTR)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    uop_valid,
    input  logic [PSEL_W-1:0]       sel_a,
    input  logic [PSEL_W-1:0]       sel_b,
    input  logic [1:0]              step_a,
    input  logic [1:0]              step_b,
    input  logic [1:0]              acc_op,
    input  logic                    ptr_wr_en,
    input  logic                    ptr_wr_bank,
    input  logic [PSEL_W-1:0]       ptr_wr_idx,
    input  logic [ADDR_W-1:0]       ptr_wr_val,
    input  logic                    mem_a_we,
    input  logic [ADDR_W-1:0]       mem_a_addr,
    input  logic [DATA_W-1:0]       mem_a_wdata,
    input  logic                    mem_b_we,
    input  logic [ADDR_W-1:0]       mem_b_addr,
    input  logic [DATA_W-1:0]       mem_b_wdata,
    output logic signed [ACC_W-1:0] acc_out,
    output logic                    acc_sat
);
    localparam int NBANK = 2;

    logic [PSEL_W-1:0] sel_v   [NBANK];
    logic [1:0]        step_v  [NBANK];
    logic              we_v    [NBANK];
    logic [ADDR_W-1:0] waddr_v [NBANK];
    logic [DATA_W-1:0] wdata_v [NBANK];
    logic [DATA_W-1:0] rd_v    [NBANK];
    logic signed [ACC_W-1:0] prod_sh;

    assign sel_v[0]   = sel_a;
    assign sel_v[1]   = sel_b;
    assign step_v[0]  = step_a;
    assign step_v[1]  = step_b;
    assign we_v[0]    = mem_a_we;
    assign we_v[1]    = mem_b_we;
    assign waddr_v[0] = mem_a_addr;
    assign waddr_v[1] = mem_b_addr;
    assign wdata_v[0] = mem_a_wdata;
    assign wdata_v[1] = mem_b_wdata;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        mac_bank #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W),
            .NPTR   (NPTR)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .op_en     (uop_valid),
            .ptr_sel   (sel_v[b]),
            .step      (step_v[b]),
            .pw_en     (ptr_wr_en && (ptr_wr_bank == 1'(b))),
            .pw_idx    (ptr_wr_idx),
            .pw_val    (ptr_wr_val),
            .mem_we    (we_v[b]),
            .mem_addr  (waddr_v[b]),
            .mem_wdata (wdata_v[b]),
            .rd_data   (rd_v[b])
        );
    end

    mac_mul #(
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W),
        .SHIFT  (PROD_SHIFT)
    ) u_mul (
        .op_a   (rd_v[0]),
        .op_b   (rd_v[1]),
        .prod_o (prod_sh)
    );

    mac_acc #(
        .ACC_W (ACC_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .op_en (uop_valid),
        .op    (acc_op),
        .prod  (prod_sh),
        .acc_q (acc_out),
        .sat_q (acc_sat)
    );

endmodule

// File: rtl/mac_dual_bank_chk.sv
module mac_dual_bank_chk #(
    parameter int ACC_W = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    uop_valid,
    input logic [1:0]              acc_op,
    input logic signed [ACC_W-1:0] prod_sh,
    input logic signed [ACC_W-1:0] acc_out,
    input logic                    acc_sat
);
    localparam logic signed [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};

    p_load_product_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && acc_op == 2'b10) |=> (acc_out == $past(prod_sh)) && !acc_sat);

    p_add_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && acc_op == 2'b01) |=>
            (acc_sat || (acc_out == $past(acc_out) + $past(prod_sh))));

    p_sat_on_rail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_sat |-> (acc_out == MAXV || acc_out == MINV));

    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (uop_valid && acc_op == 2'b11) |=> (acc_out == '0) && !acc_sat);

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!uop_valid || acc_op == 2'b00) |=> ($stable(acc_out) && $stable(acc_sat)));

endmodule

bind mac_dual_bank mac_dual_bank_chk #(.ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .uop_valid (uop_valid),
    .acc_op    (acc_op),
    .prod_sh   (prod_sh),
    .acc_out   (acc_out),
    .acc_sat   (acc_sat)
);

// File: tb/tb_mac_dual_bank.sv
`timescale 1ns/1ps
module tb_mac_dual_bank;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              uop_valid = 1'b0;
    logic [1:0]        sel_a = '0, sel_b = '0, step_a = '0, step_b = '0, acc_op = '0;
    logic              ptr_wr_en = 1'b0, ptr_wr_bank = 1'b0;
    logic [1:0]        ptr_wr_idx = '0;
    logic [7:0]        ptr_wr_val = '0;
    logic              mem_a_we = 1'b0, mem_b_we = 1'b0;
    logic [7:0]        mem_a_addr = '0, mem_b_addr = '0;
    logic [15:0]       mem_a_wdata = '0, mem_b_wdata = '0;
    logic signed [23:0] acc_out;
    logic              acc_sat;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mac_dual_bank dut (
        .clk(clk), .rst_n(rst_n), .uop_valid(uop_valid),
        .sel_a(sel_a), .sel_b(sel_b), .step_a(step_a), .step_b(step_b),
        .acc_op(acc_op), .ptr_wr_en(ptr_wr_en), .ptr_wr_bank(ptr_wr_bank),
        .ptr_wr_idx(ptr_wr_idx), .ptr_wr_val(ptr_wr_val),
        .mem_a_we(mem_a_we), .mem_a_addr(mem_a_addr), .mem_a_wdata(mem_a_wdata),
        .mem_b_we(mem_b_we), .mem_b_addr(mem_b_addr), .mem_b_wdata(mem_b_wdata),
        .acc_out(acc_out), .acc_sat(acc_sat)
    );

    // {sel_a, sel_b, step_a, step_b, acc_op, expected acc}
    localparam int NVEC = 16;
    localparam logic [33:0] VEC [NVEC] = '{
        {2'd0, 2'd0, 2'd0, 2'd0, 2'd2, 24'd6},
        {2'd0, 2'd0, 2'd1, 2'd1, 2'd1, 24'd12},
        {2'd0, 2'd0, 2'd1, 2'd2, 2'd1, 24'd24},
        {2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 24'd36},
        {2'd1, 2'd1, 2'd2, 2'd0, 2'd2, 24'd35},
        {2'd1, 2'd2, 2'd0, 2'd1, 2'd1, 24'd39},
        {2'd1, 2'd2, 2'd3, 2'd3, 2'd1, 24'd47},
        {2'd1, 2'd2, 2'd0, 2'd0, 2'd1, 24'd55},
        {2'd3, 2'd1, 2'd1, 2'd2, 2'd2, 24'd1785},
        {2'd3, 2'd3, 2'd0, 2'd2, 2'd2, 24'd0},
        {2'd2, 2'd3, 2'd0, 2'd0, 2'd2, 24'd2550},
        {2'd0, 2'd1, 2'd0, 2'd0, 2'd1, 24'd2574},
        {2'd2, 2'd1, 2'd1, 2'd1, 2'd0, 24'd2574},
        {2'd2, 2'd1, 2'd0, 2'd0, 2'd2, 24'd77},
        {2'd0, 2'd0, 2'd1, 2'd1, 2'd3, 24'd0},
        {2'd0, 2'd0, 2'd0, 2'd0, 2'd1, 24'd20}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Called on a falling edge; returns on the next falling edge with the result visible.
    task automatic uop(input logic en, input logic [1:0] sa, input logic [1:0] sb,
                       input logic [1:0] sta, input logic [1:0] stb, input logic [1:0] op);
        uop_valid = en; sel_a = sa; sel_b = sb; step_a = sta; step_b = stb; acc_op = op;
        @(negedge clk);
        uop_valid = 1'b0; step_a = '0; step_b = '0; acc_op = '0;
    endtask

    task automatic setp(input logic bank, input logic [1:0] idx, input logic [7:0] val);
        ptr_wr_en = 1'b1; ptr_wr_bank = bank; ptr_wr_idx = idx; ptr_wr_val = val;
        @(negedge clk);
        ptr_wr_en = 1'b0;
    endtask

    task automatic wmem(input logic bank, input logic [7:0] addr, input logic [15:0] data);
        if (bank) begin mem_b_we = 1'b1; mem_b_addr = addr; mem_b_wdata = data; end
        else      begin mem_a_we = 1'b1; mem_a_addr = addr; mem_a_wdata = data; end
        @(negedge clk);
        mem_a_we = 1'b0; mem_b_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 acc after reset", int'(acc_out), 0);
        chk("R1 sat after reset", int'(acc_sat), 0);

        // R2: fill both banks, word k = 16k, so a load yields ptr_a*ptr_b.
        for (int k = 0; k < 256; k++) begin
            mem_a_we = 1'b1; mem_a_addr = 8'(k); mem_a_wdata = 16'(k * 16);
            mem_b_we = 1'b1; mem_b_addr = 8'(k); mem_b_wdata = 16'(k * 16);
            @(negedge clk);
        end
        mem_a_we = 1'b0; mem_b_we = 1'b0;

        setp(1'b0, 2'd0, 8'd2);   setp(1'b0, 2'd1, 8'd5);
        setp(1'b0, 2'd2, 8'd10);  setp(1'b0, 2'd3, 8'd255);
        setp(1'b1, 2'd0, 8'd3);   setp(1'b1, 2'd1, 8'd7);
        setp(1'b1, 2'd2, 8'd1);   setp(1'b1, 2'd3, 8'd0);

        // Table walk: R3 R4 R6 R7 R8 R10 (wrap in rows 9 to 11, code 3 in rows 7 and 8)
        for (int i = 0; i < NVEC; i++) begin
            uop(1'b1, VEC[i][33:32], VEC[i][31:30], VEC[i][29:28], VEC[i][27:26], VEC[i][25:24]);
            chk($sformatf("R3/R4/R7/R8/R10 vector %0d", i), int'(acc_out), int'($signed(VEC[i][23:0])));
        end

        // R6: idle micro-op changes nothing, including pointers.
        uop(1'b0, 2'd0, 2'd0, 2'd1, 2'd1, 2'd1);
        chk("R6 idle keeps acc", int'(acc_out), 20);
        uop(1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2);
        chk("R6 idle did not step", int'(acc_out), 20);

        // R9: write outranks step in the same cycle; read used old pointer.
        ptr_wr_en = 1'b1; ptr_wr_bank = 1'b0; ptr_wr_idx = 2'd0; ptr_wr_val = 8'd100;
        uop(1'b1, 2'd0, 2'd0, 2'd1, 2'd0, 2'd1);
        ptr_wr_en = 1'b0;
        chk("R9 same-cycle read uses old pointer", int'(acc_out), 40);
        uop(1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2);
        chk("R9 write wins over step", int'(acc_out), 400);
        setp(1'b0, 2'd1, 8'd9);
        uop(1'b1, 2'd1, 2'd0, 2'd0, 2'd0, 2'd2);
        chk("R9 written pointer used next cycle", int'(acc_out), 36);

        // R2 R3: negative operand, floor rounding of the scaled product.
        wmem(1'b0, 8'd50, 16'(-1001));
        wmem(1'b1, 8'd20, 16'd320);
        setp(1'b0, 2'd2, 8'd50);
        setp(1'b1, 2'd2, 8'd20);
        uop(1'b1, 2'd2, 2'd2, 2'd0, 2'd0, 2'd2);
        chk("R3 signed floor product", int'(acc_out), -1252);

        // R5: positive clip.
        wmem(1'b0, 8'd60, 16'd32767);
        wmem(1'b1, 8'd60, 16'd32767);
        setp(1'b0, 2'd3, 8'd60);
        setp(1'b1, 2'd3, 8'd60);
        uop(1'b1, 2'd3, 2'd3, 2'd0, 2'd0, 2'd2);
        chk("R3 large load", int'(acc_out), 4194048);
        uop(1'b1, 2'd3, 2'd3, 2'd0, 2'd0, 2'd1);
        chk("R4 add below rail", int'(acc_out), 8388096);
        chk("R5 no clip yet", int'(acc_sat), 0);
        uop(1'b1, 2'd3, 2'd3, 2'd0, 2'd0, 2'd1);
        chk("R5 positive rail", int'(acc_out), 8388607);
        chk("R5 sat flag set", int'(acc_sat), 1);
        uop(1'b1, 2'd3, 2'd3, 2'd0, 2'd0, 2'd1);
        chk("R5 stays on rail", int'(acc_out), 8388607);
        uop(1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3);
        chk("R6 clear", int'(acc_out), 0);
        chk("R6 clear drops sat", int'(acc_sat), 0);

        // R5: negative clip.
        wmem(1'b0, 8'd61, 16'h8000);
        setp(1'b0, 2'd3, 8'd61);
        uop(1'b1, 2'd3, 2'd3, 2'd0, 2'd0, 2'd2);
        chk("R3 negative load", int'(acc_out), -4194176);
        uop(1'b1, 2'd3, 2'd3, 2'd0, 2'd0, 2'd1);
        chk("R4 negative add", int'(acc_out), -8388352);
        uop(1'b1, 2'd3, 2'd3, 2'd0, 2'd0, 2'd1);
        chk("R5 negative rail", int'(acc_out), -8388608);
        chk("R5 sat flag negative", int'(acc_sat), 1);
        uop(1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 2'd2);
        chk("R5 load clears sat", int'(acc_sat), 0);
        chk("R3 load after clip", int'(acc_out), 400);

        // R1: mid-run reset returns pointers to 0, memory is kept.
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 acc in reset", int'(acc_out), 0);
        chk("R1 sat in reset", int'(acc_sat), 0);
        rst_n = 1'b1;
        @(negedge clk);
        wmem(1'b0, 8'd0, 16'd256);
        wmem(1'b1, 8'd0, 16'd512);
        uop(1'b1, 2'd3, 2'd1, 2'd0, 2'd0, 2'd2);
        chk("R1 pointers at zero after reset", int'(acc_out), 512);
        uop(1'b1, 2'd2, 2'd2, 2'd0, 2'd0, 2'd2);
        chk("R1 memory kept through reset", int'(acc_out), 512);

        finish_run();
    end

endmodule